// File: doc/BRIEF.md
# SPI Command Word Receiver

This block sits on the target side of a four-wire serial link and turns each framed 16-bit word from an external controller into a command code and a payload. The serial clock idles low and every bit is taken on its rising edge, most significant bit first. The first four bits of a frame are the command code and the remaining twelve are the payload. The serial inputs are not clocked by the serial clock. Two-stage synchronisers bring them into the much faster system clock, and an edge detector picks out the rising serial-clock edges there.

Each finished word raises a single-cycle valid pulse. The code and the payload appear on held outputs and stay there until the next word arrives. One command code is reserved as a write to a local configuration register, which takes the low bits of the payload. Other codes are reported but leave that register unchanged. If the select line is released before sixteen bits have arrived, the partial word is dropped.

Top module: `spi_cmd_rx`

## Requirements
- R1: While reset is held and just after it is released, cmd_valid is 0 and cmd_code, cmd_data and cfg_reg are all zero.
- R2: A frame is 16 bits sent most significant bit first. The first 4 bits received become cmd_code[3:0] and the next 12 become cmd_data[11:0].
- R3: Each bit is the level of spi_mosi at a rising edge of spi_sck. A change of spi_mosi while spi_sck is high does not alter the received bit.
- R4: Every complete 16-bit word produces exactly one cmd_valid pulse, and that pulse is one system-clock cycle wide.
- R5: If spi_csel_n goes high after fewer than 16 bits, no pulse is produced, the outputs and cfg_reg are unchanged, and the next frame starts again from bit 0.
- R6: Edges on spi_sck while spi_csel_n is high are ignored. They produce no pulse and do not shift into the next frame.
- R7: A word whose code equals CFG_OPCODE (default 4'h1) loads cmd_data[CFG_W-1:0] (default 8 bits) into cfg_reg. The new value is visible in the same cycle as cmd_valid.
- R8: A word with any other code is reported on cmd_code and cmd_data but leaves cfg_reg unchanged.
- R9: cmd_code and cmd_data change only together with a cmd_valid pulse, and hold their values between words.
- R10: The block works correctly when spi_sck high and low phases are each as short as 2 system-clock periods.
- R11: When more than 16 clocks arrive in one select period, every further group of 16 bits forms a new word with its own pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the controller, idle low |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_csel_n | input | 1 | Frame select; active low with the default CS_ACTIVE_LOW=1 |
| cmd_valid | output | 1 | One-cycle pulse when a complete word is received |
| cmd_code | output | CMD_W (4) | Command field of the last word |
| cmd_data | output | DATA_W (12) | Payload field of the last word |
| cfg_reg | output | CFG_W (8) | Configuration register written by the config opcode |

## Verification
Frames carrying the configuration opcode and frames carrying other codes are sent with alternating payload patterns. These show whether field splitting and the register write are right, and whether foreign codes leave the register alone. One pattern moves spi_mosi while the clock is high, which separates rising-edge sampling from falling-edge sampling. Truncated frames and clock bursts with the select line released show that no stray bit is carried over into the next frame. A 32-bit burst under a single select and a frame at the shortest allowed clock phases test word re-framing and the synchroniser margin.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   // Field widths of the command word
   localparam int unsigned CODE_BITS = 4;
   localparam int unsigned DATA_BITS = 12;

   // Default opcode that addresses the configuration register
   localparam logic [CODE_BITS-1:0] OPC_CFG_WRITE = 4'h1;

   typedef struct packed {
      logic [CODE_BITS-1:0] code;
      logic [DATA_BITS-1:0] data;
   } cmd_word_t;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
   parameter int unsigned WIDTH   = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_cmd_sync: STAGES must be at least 2");
      end
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], din[b]};
         end
         assign dout[b] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              mosi_s,
   input  logic              sel_act,
   output logic              word_done,
   output logic [WORD_W-1:0] word
);
   localparam int unsigned CNT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

   logic             sck_q;
   logic             sck_rise;
   logic [CNT_W-1:0] bit_cnt;
   logic [WORD_W-1:0] shreg;

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("spi_cmd_shift: WORD_W must be at least 2");
      end
   endgenerate

   assign sck_rise = sck_s & ~sck_q;
   assign word     = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q     <= 1'b0;
         bit_cnt   <= '0;
         shreg     <= '0;
         word_done <= 1'b0;
      end else begin
         sck_q     <= sck_s;
         word_done <= 1'b0;
         if (!sel_act) begin
            bit_cnt <= '0;
         end else if (sck_rise) begin
            shreg <= {shreg[WORD_W-2:0], mosi_s};
            if (bit_cnt == LAST_BIT) begin
               bit_cnt   <= '0;
               word_done <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode #(
   parameter int unsigned CMD_W  = 4,
   parameter int unsigned DATA_W = 12,
   parameter int unsigned CFG_W  = 8,
   parameter logic [CMD_W-1:0] CFG_OPCODE = 4'h1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    word_done,
   input  logic [CMD_W+DATA_W-1:0] word,
   output logic                    cmd_valid,
   output logic [CMD_W-1:0]        cmd_code,
   output logic [DATA_W-1:0]       cmd_data,
   output logic [CFG_W-1:0]        cfg_reg
);
   logic [CMD_W-1:0]  code_w;
   logic [DATA_W-1:0] data_w;

   generate
      if (CFG_W > DATA_W || CFG_W == 0) begin : g_bad_cfg
         $error("spi_cmd_decode: CFG_W must be 1..DATA_W");
      end
   endgenerate

   assign code_w = word[CMD_W+DATA_W-1:DATA_W];
   assign data_w = word[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_code  <= '0;
         cmd_data  <= '0;
         cfg_reg   <= '0;
      end else begin
         cmd_valid <= word_done;
         if (word_done) begin
            cmd_code <= code_w;
            cmd_data <= data_w;
            if (code_w == CFG_OPCODE) cfg_reg <= data_w[CFG_W-1:0];
         end
      end
   end
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
   import spi_cmd_pkg::*;
#(
   parameter int unsigned CMD_W         = CODE_BITS,
   parameter int unsigned DATA_W        = DATA_BITS,
   parameter int unsigned CFG_W         = 8,
   parameter logic [CMD_W-1:0] CFG_OPCODE = OPC_CFG_WRITE,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          CS_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_mosi,
   input  logic              spi_csel_n,
   output logic              cmd_valid,
   output logic [CMD_W-1:0]  cmd_code,
   output logic [DATA_W-1:0] cmd_data,
   output logic [CFG_W-1:0]  cfg_reg
);
   localparam int unsigned WORD_W = CMD_W + DATA_W;
   localparam logic [2:0]  SYNC_RST = {CS_ACTIVE_LOW, 1'b0, 1'b0};

   logic [2:0]        raw_in;
   logic [2:0]        sync_out;
   logic              sel_act;
   logic              word_done;
   logic [WORD_W-1:0] word;

   assign raw_in = {spi_csel_n, spi_mosi, spi_sck};

   spi_cmd_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in),
      .dout (sync_out)
   );

   generate
      if (CS_ACTIVE_LOW) begin : g_sel_low
         assign sel_act = ~sync_out[2];
      end else begin : g_sel_high
         assign sel_act = sync_out[2];
      end
   endgenerate

   spi_cmd_shift #(
      .WORD_W(WORD_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_s    (sync_out[0]),
      .mosi_s   (sync_out[1]),
      .sel_act  (sel_act),
      .word_done(word_done),
      .word     (word)
   );

   spi_cmd_decode #(
      .CMD_W     (CMD_W),
      .DATA_W    (DATA_W),
      .CFG_W     (CFG_W),
      .CFG_OPCODE(CFG_OPCODE)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_done(word_done),
      .word     (word),
      .cmd_valid(cmd_valid),
      .cmd_code (cmd_code),
      .cmd_data (cmd_data),
      .cfg_reg  (cfg_reg)
   );
endmodule

// File: rtl/spi_cmd_rx_chk.sv
module spi_cmd_rx_chk #(
   parameter int unsigned CMD_W  = 4,
   parameter int unsigned DATA_W = 12,
   parameter int unsigned CFG_W  = 8,
   parameter logic [CMD_W-1:0] CFG_OPCODE = 4'h1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              spi_csel_n,
   input logic              cmd_valid,
   input logic [CMD_W-1:0]  cmd_code,
   input logic [DATA_W-1:0] cmd_data,
   input logic [CFG_W-1:0]  cfg_reg
);
   // R4
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   // R7
   cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == CFG_OPCODE) |-> (cfg_reg == cmd_data[CFG_W-1:0]));

   // R8
   cfg_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_reg) |-> (cmd_valid && cmd_code == CFG_OPCODE));

   // R9
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmd_data) |-> cmd_valid);

   // R9
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmd_code) |-> cmd_valid);
endmodule

bind spi_cmd_rx spi_cmd_rx_chk #(
   .CMD_W     (CMD_W),
   .DATA_W    (DATA_W),
   .CFG_W     (CFG_W),
   .CFG_OPCODE(CFG_OPCODE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .spi_csel_n(spi_csel_n),
   .cmd_valid (cmd_valid),
   .cmd_code  (cmd_code),
   .cmd_data  (cmd_data),
   .cfg_reg   (cfg_reg)
);

// File: tb/spi_cmd_rx_test.sv
`timescale 1ns/1ps
module spi_cmd_rx_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sck = 1'b0;
   logic        spi_mosi = 1'b0;
   logic        spi_csel_n = 1'b1;
   logic        cmd_valid;
   logic [3:0]  cmd_code;
   logic [11:0] cmd_data;
   logic [7:0]  cfg_reg;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // monitor
   int          pulses = 0;
   int          run_len = 0;
   int          max_run = 0;
   logic [3:0]  last_code = '0, prev_code = '0;
   logic [11:0] last_data = '0, prev_data = '0;

   always #2 clk = ~clk;

   spi_cmd_rx uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .spi_sck   (spi_sck),
      .spi_mosi  (spi_mosi),
      .spi_csel_n(spi_csel_n),
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .cmd_data  (cmd_data),
      .cfg_reg   (cfg_reg)
   );

   always @(negedge clk) begin
      if (rst_n && cmd_valid) begin
         if (run_len == 0) begin
            pulses    <= pulses + 1;
            prev_code <= last_code;
            prev_data <= last_data;
            last_code <= cmd_code;
            last_data <= cmd_data;
         end
         run_len <= run_len + 1;
         if (run_len + 1 > max_run) max_run <= run_len + 1;
      end else begin
         run_len <= 0;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Send n bits MSB first; half = system clocks per SCK phase;
   // wiggle flips MOSI midway through each high phase.
   task automatic send(input logic [31:0] bits, input int n, input int half,
                       input bit wiggle);
      spi_csel_n = 1'b0;
      wclk(half);
      for (int i = n - 1; i >= 0; i--) begin
         spi_mosi = bits[i];
         wclk(half);
         spi_sck = 1'b1;
         if (wiggle) begin
            wclk(half / 2);
            spi_mosi = ~bits[i];
            wclk(half - half / 2);
         end else begin
            wclk(half);
         end
         spi_sck = 1'b0;
      end
      wclk(half);
      spi_csel_n = 1'b1;
      wclk(12);
   endtask

   task automatic t_reset();
      wclk(3);
      chk(cmd_valid == 1'b0, "R1", "valid in reset", cmd_valid, 0);
      chk(cfg_reg == 8'h00, "R1", "cfg in reset", cfg_reg, 0);
      rst_n = 1'b1;
      wclk(3);
      chk(cmd_code == 4'h0 && cmd_data == 12'h000, "R1", "fields after reset",
          {cmd_code, cmd_data}, 0);
      chk(cfg_reg == 8'h00 && pulses == 0, "R1", "cfg after reset", cfg_reg, 0);
   endtask

   task automatic t_config();
      int p0 = pulses;
      send({16'h0, 4'h1, 12'hA5C}, 16, 4, 1'b0);
      chk(pulses == p0 + 1, "R4", "one pulse per word", pulses - p0, 1);
      chk(max_run == 1, "R4", "pulse width", max_run, 1);
      chk(last_code == 4'h1, "R2", "code field", last_code, 1);
      chk(last_data == 12'hA5C, "R2", "data field", last_data, 12'hA5C);
      chk(cfg_reg == 8'h5C, "R7", "config write", cfg_reg, 8'h5C);
   endtask

   task automatic t_other();
      send({16'h0, 4'h9, 12'h3F0}, 16, 4, 1'b0);
      chk(last_code == 4'h9 && last_data == 12'h3F0, "R8", "foreign code passes",
          {last_code, last_data}, 16'h93F0);
      chk(cfg_reg == 8'h5C, "R8", "cfg untouched", cfg_reg, 8'h5C);
   endtask

   task automatic t_edge();
      send({16'h0, 4'h1, 12'h0F3}, 16, 4, 1'b1);
      chk(last_data == 12'h0F3 && last_code == 4'h1, "R3", "rising-edge sampling",
          {last_code, last_data}, 16'h10F3);
      chk(cfg_reg == 8'hF3, "R3", "cfg after wiggle frame", cfg_reg, 8'hF3);
   endtask

   task automatic t_partial();
      int p0 = pulses;
      send({22'h0, 10'h3FF}, 10, 4, 1'b0);
      chk(pulses == p0, "R5", "no pulse on short frame", pulses - p0, 0);
      chk(cfg_reg == 8'hF3 && cmd_data == 12'h0F3, "R5", "outputs kept",
          {cfg_reg, cmd_data}, {8'hF3, 12'h0F3});
      send({16'h0, 4'h1, 12'h011}, 16, 4, 1'b0);
      chk(pulses == p0 + 1 && last_data == 12'h011, "R5", "restart after abort",
          last_data, 12'h011);
      chk(cfg_reg == 8'h11, "R5", "cfg after restart", cfg_reg, 8'h11);
   endtask

   task automatic t_idle_clock();
      int p0 = pulses;
      spi_mosi = 1'b1;
      for (int i = 0; i < 5; i++) begin
         wclk(4); spi_sck = 1'b1; wclk(4); spi_sck = 1'b0;
      end
      wclk(10);
      chk(pulses == p0 && cmd_data == 12'h011, "R6", "idle clocks ignored",
          pulses - p0, 0);
      send({16'h0, 4'h2, 12'h000}, 16, 4, 1'b0);
      chk(last_code == 4'h2 && last_data == 12'h000, "R6", "no carried bits",
          {last_code, last_data}, 16'h2000);
   endtask

   task automatic t_hold();
      int p0 = pulses;
      wclk(60);
      chk(pulses == p0 && cmd_code == 4'h2 && cmd_data == 12'h000, "R9",
          "fields held", {cmd_code, cmd_data}, 16'h2000);
      chk(cmd_valid == 1'b0, "R9", "valid low between words", cmd_valid, 0);
   endtask

   task automatic t_fast();
      send({16'h0, 4'h1, 12'hFFE}, 16, 2, 1'b0);
      chk(last_code == 4'h1 && last_data == 12'hFFE, "R10", "fast clock word",
          {last_code, last_data}, 16'h1FFE);
      chk(cfg_reg == 8'hFE, "R10", "fast clock cfg", cfg_reg, 8'hFE);
   endtask

   task automatic t_burst();
      int p0 = pulses;
      send({4'h3, 12'h123, 4'h1, 12'h0AB}, 32, 4, 1'b0);
      chk(pulses == p0 + 2, "R11", "two words in one select", pulses - p0, 2);
      chk(prev_code == 4'h3 && prev_data == 12'h123, "R11", "first word",
          {prev_code, prev_data}, 16'h3123);
      chk(last_code == 4'h1 && last_data == 12'h0AB, "R11", "second word",
          {last_code, last_data}, 16'h10AB);
      chk(cfg_reg == 8'hAB && max_run == 1, "R11", "cfg after burst", cfg_reg, 8'hAB);
   endtask

   initial begin
      t_reset();
      t_config();
      t_other();
      t_edge();
      t_partial();
      t_idle_clock();
      t_hold();
      t_fast();
      t_burst();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule